// File: doc/BRIEF.md
# Slot-Aligned Transmit Elastic Buffer

This block sits between a half-duplex MAC's nibble-wide transmit path and a scheduler that issues a one-cycle grant pulse when the node's transmit opportunity on a shared multidrop segment begins. A frame that the MAC starts while the node has no opportunity is held in a small FIFO. When the grant arrives, the held nibbles are replayed first and the rest of the frame follows, so the whole frame reaches the line late by the FIFO occupancy. A frame that the MAC starts inside an open opportunity passes straight through with one cycle of latency.

If the FIFO fills before the grant arrives, the block discards the partial frame and raises a logical collision toward the MAC. It keeps carrier sense high until the next grant, so the MAC backs off and defers. When the next grant arrives, carrier sense drops and an opportunity window of `OPEN_WIN` cycles opens for the retry. The FIFO can fill in the same cycle that the grant arrives. In that case the grant wins: the frame is sent whole, no collision is raised, and carrier sense never drops early. The depth `DEPTH` sets how long a frame may wait before it overflows.

Top module: `slot_tx_elastic`

## Requirements
- R1: After reset, `line_txen`, `mac_crs` and `mac_col` are all 0.
- R2: A frame the MAC starts while no opportunity is open produces no line activity before a grant, and `mac_crs` is 1 from the cycle after the frame starts until its last nibble has left.
- R3: When a grant arrives while a frame is held and the FIFO has not filled, the first nibble appears on the line in the cycle after the grant. All nibbles then follow in order and back-to-back, including frames that ended before the grant.
- R4: A frame whose first nibble coincides with a grant, or starts during the `OPEN_WIN` cycles that follow a grant, is sent with each nibble appearing exactly one cycle after the MAC drives it.
- R5: If the `DEPTH`-th nibble of a held frame is written in a cycle with no grant, `mac_col` is 1 from the next cycle, `mac_crs` stays 1, nothing reaches the line, and the held nibbles are discarded.
- R6: `mac_col`, once raised, stays 1 without a gap while `mac_txen` is 1. It falls in the cycle after the MAC drops `mac_txen`.
- R7: After a logical collision, `mac_crs` stays 1 until a grant arrives, and it is 0 in the cycle after that grant.
- R8: If the `DEPTH`-th nibble is written in the same cycle as a grant, no collision occurs. The full frame is sent starting the cycle after the grant, and `mac_crs` does not drop before the last nibble.
- R9: A grant that arrives while `mac_col` is 1 is ignored: `mac_crs` stays 1 and a later grant is needed.
- R10: An opportunity window not used within `OPEN_WIN` cycles after its grant closes. A frame started after that is held until the next grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the MAC side and the line side |
| rst_n | input | 1 | Active-low synchronous reset |
| mac_txen | input | 1 | MAC transmit enable |
| mac_txd | input | 4 | MAC transmit nibble |
| slot_grant | input | 1 | One-cycle pulse marking the start of this node's transmit opportunity |
| line_txen | output | 1 | Transmit enable toward the line |
| line_txd | output | 4 | Nibble toward the line |
| mac_crs | output | 1 | Carrier sense to the MAC |
| mac_col | output | 1 | Logical collision to the MAC |

## Verification
The FIFO reaching full and the opportunity grant can fall in the same cycle. The bench provokes this by starting a frame with no opportunity open and pulsing the grant exactly in the cycle that carries the `DEPTH`-th nibble. The outcome is judged at the ports: no collision, carrier sense held without a gap, and the complete frame on the line starting one cycle after the grant. Neighbouring cases are also run: a grant one cycle late, which must collide, and a grant during the collision, which must be ignored.

// File: rtl/slot_etx_pkg.sv
package slot_etx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // no frame, no opportunity
        ST_OPEN,   // opportunity held, waiting for the MAC
        ST_HOLD,   // frame being buffered, waiting for grant
        ST_SEND,   // frame going to the line
        ST_COLL,   // logical collision toward the MAC
        ST_WAIT    // collision over, deferring until next grant
    } etx_state_e;

endpackage

// File: rtl/etx_nib_fifo.sv
module etx_nib_fifo #(
    parameter int W     = 4,
    parameter int DEPTH = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic                         clr,
    input  logic [W-1:0]                 din,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [W-1:0] mem [DEPTH];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else begin
            if (push) d.wr = nxt(q.wr);
            if (pop)  d.rd = nxt(q.rd);
            case ({push, pop})
                2'b10:   d.cnt = q.cnt + 1'b1;
                2'b01:   d.cnt = q.cnt - 1'b1;
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem[q.wr] <= din;
    end

    assign dout  = mem[q.rd];
    assign count = q.cnt;

endmodule

// File: rtl/etx_slot_fsm.sv
module etx_slot_fsm
    import slot_etx_pkg::*;
#(
    parameter int W        = 4,
    parameter int DEPTH    = 12,
    parameter int OPEN_WIN = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         mac_txen,
    input  logic [W-1:0]                 mac_txd,
    input  logic                         slot_grant,
    input  logic [$clog2(DEPTH+1)-1:0]   fifo_cnt,
    input  logic [W-1:0]                 fifo_head,
    output logic                         fifo_push,
    output logic                         fifo_pop,
    output logic                         fifo_clr,
    output logic                         line_txen,
    output logic [W-1:0]                 line_txd,
    output logic                         crs,
    output logic                         col
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int WW = (OPEN_WIN > 1) ? $clog2(OPEN_WIN) : 1;

    typedef struct packed {
        etx_state_e     st;
        logic [WW-1:0]  win;
        logic           done;   // MAC has ended the current frame
        logic           txen;
        logic [W-1:0]   txd;
    } fsm_st_t;

    fsm_st_t q, d;
    logic    wr_ok;

    always_comb begin
        d         = q;
        d.txen    = 1'b0;
        fifo_push = 1'b0;
        fifo_pop  = 1'b0;
        fifo_clr  = 1'b0;
        wr_ok     = mac_txen && !q.done;
        case (q.st)
            ST_IDLE, ST_OPEN: begin
                if (mac_txen && (slot_grant || q.st == ST_OPEN)) begin
                    d.st   = ST_SEND;       // opportunity held: pass through
                    d.done = 1'b0;
                    d.txen = 1'b1;
                    d.txd  = mac_txd;
                end else if (mac_txen) begin
                    d.st      = ST_HOLD;    // no opportunity: start buffering
                    d.done    = 1'b0;
                    fifo_push = 1'b1;
                end else if (q.st == ST_IDLE && slot_grant) begin
                    d.st  = ST_OPEN;
                    d.win = WW'(OPEN_WIN - 1);
                end else if (q.st == ST_OPEN) begin
                    if (q.win == '0) d.st = ST_IDLE;
                    else             d.win = q.win - 1'b1;
                end
            end
            ST_HOLD: begin
                if (!mac_txen) d.done = 1'b1;
                if (slot_grant) begin
                    // grant has priority over a simultaneous fill
                    d.st      = ST_SEND;
                    fifo_pop  = 1'b1;
                    fifo_push = wr_ok;
                    d.txen    = 1'b1;
                    d.txd     = fifo_head;
                end else if (wr_ok && fifo_cnt == CW'(DEPTH - 1)) begin
                    d.st     = ST_COLL;
                    fifo_clr = 1'b1;
                end else begin
                    fifo_push = wr_ok;
                end
            end
            ST_SEND: begin
                if (!mac_txen) d.done = 1'b1;
                if (fifo_cnt != '0) begin
                    fifo_pop  = 1'b1;
                    fifo_push = wr_ok;
                    d.txen    = 1'b1;
                    d.txd     = fifo_head;
                end else if (wr_ok) begin
                    d.txen = 1'b1;
                    d.txd  = mac_txd;
                end else begin
                    d.st = ST_IDLE;
                end
            end
            ST_COLL: begin
                if (!mac_txen) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (slot_grant) begin
                    d.st  = ST_OPEN;
                    d.win = WW'(OPEN_WIN - 1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign line_txen = q.txen;
    assign line_txd  = q.txd;
    assign col       = (q.st == ST_COLL);
    assign crs       = (q.st == ST_HOLD) || (q.st == ST_SEND) ||
                       (q.st == ST_COLL) || (q.st == ST_WAIT);

endmodule

// File: rtl/slot_tx_elastic.sv
module slot_tx_elastic #(
    parameter int NIB_W    = 4,
    parameter int DEPTH    = 12,
    parameter int OPEN_WIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mac_txen,
    input  logic [NIB_W-1:0] mac_txd,
    input  logic             slot_grant,
    output logic             line_txen,
    output logic [NIB_W-1:0] line_txd,
    output logic             mac_crs,
    output logic             mac_col
);
    localparam int CW = $clog2(DEPTH + 1);

    logic             push, pop, clr;
    logic [NIB_W-1:0] head;
    logic [CW-1:0]    cnt;

    etx_nib_fifo #(.W(NIB_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .clr   (clr),
        .din   (mac_txd),
        .dout  (head),
        .count (cnt)
    );

    etx_slot_fsm #(.W(NIB_W), .DEPTH(DEPTH), .OPEN_WIN(OPEN_WIN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mac_txen   (mac_txen),
        .mac_txd    (mac_txd),
        .slot_grant (slot_grant),
        .fifo_cnt   (cnt),
        .fifo_head  (head),
        .fifo_push  (push),
        .fifo_pop   (pop),
        .fifo_clr   (clr),
        .line_txen  (line_txen),
        .line_txd   (line_txd),
        .crs        (mac_crs),
        .col        (mac_col)
    );

endmodule

// File: rtl/slot_tx_elastic_chk.sv
module slot_tx_elastic_chk (
    input logic clk,
    input logic rst_n,
    input logic mac_txen,
    input logic slot_grant,
    input logic line_txen,
    input logic mac_crs,
    input logic mac_col
);
    // R6
    col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_col && mac_txen) |=> mac_col);

    // R6
    col_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_col && !mac_txen) |=> !mac_col);

    // R5
    col_crs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mac_col |-> mac_crs);

    // R5
    col_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mac_col |-> !line_txen);

    // R7
    crs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mac_crs) |-> ($past(line_txen) || $past(slot_grant)));

    // R2
    line_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_txen) |-> ($past(slot_grant) || !$past(mac_crs)));
endmodule

bind slot_tx_elastic slot_tx_elastic_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mac_txen   (mac_txen),
    .slot_grant (slot_grant),
    .line_txen  (line_txen),
    .mac_crs    (mac_crs),
    .mac_col    (mac_col)
);

// File: tb/slot_tx_elastic_tb.sv
module slot_tx_elastic_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 12;
    localparam int OPEN_WIN   = 4;
    localparam int JAM        = 8;
    localparam int SPAN       = 110;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mac_txen = 1'b0;
    logic [3:0] mac_txd = '0;
    logic       slot_grant = 1'b0;
    logic       line_txen;
    logic [3:0] line_txd;
    logic       mac_crs;
    logic       mac_col;

    int nchk  = 0;
    int nfail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    slot_tx_elastic #(.NIB_W(4), .DEPTH(DEPTH), .OPEN_WIN(OPEN_WIN)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mac_txen   (mac_txen),
        .mac_txd    (mac_txd),
        .slot_grant (slot_grant),
        .line_txen  (line_txen),
        .line_txd   (line_txd),
        .mac_crs    (mac_crs),
        .mac_col    (mac_col)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One scenario: MAC model starts an n-nibble frame at cycle s, grants at
    // cycles g and g2 (negative = none). On collision the MAC jams JAM cycles,
    // then defers until carrier sense drops and resends from the start.
    task automatic run_case(input string req, input int s, input int n,
                            input int g, input int g2, input int exp_col,
                            input int exp_first, input logic [3:0] base);
        int ph = 0;
        int idx = 0;
        int jc = 0;
        int col_first = -1;
        int col_cnt = 0;
        int first = -1;
        int last = -1;
        int mism = 0;
        int bad_act = 0;
        int bad_exp = 0;
        int crs_gap = 0;
        logic [3:0] got[$];
        logic crs_hist[SPAN];
        for (int c = 0; c < SPAN; c++) begin
            @(negedge clk);
            crs_hist[c] = mac_crs;
            if (mac_col) begin
                if (col_first < 0) col_first = c;
                col_cnt++;
            end
            if (line_txen) begin
                if (first < 0) first = c;
                last = c;
                got.push_back(line_txd);
            end
            if (ph == 0 && c == s) begin ph = 1; idx = 0; end
            if (ph == 1 && mac_col) begin ph = 2; jc = 0; end
            if (ph == 3 && !mac_crs) begin ph = 1; idx = 0; end
            slot_grant = (c == g) || (c == g2);
            case (ph)
                1: begin
                    mac_txen = 1'b1;
                    mac_txd  = base + 4'(idx);
                    idx++;
                    if (idx == n) ph = 4;
                end
                2: begin
                    if (jc < JAM) begin
                        mac_txen = 1'b1;
                        mac_txd  = 4'hA;
                        jc++;
                    end else begin
                        mac_txen = 1'b0;
                        ph = 3;
                    end
                end
                default: mac_txen = 1'b0;
            endcase
        end
        @(negedge clk);
        mac_txen = 1'b0;
        slot_grant = 1'b0;

        check(col_first == exp_col, req, "first collision cycle", col_first, exp_col);
        check(first == exp_first, req, "first line nibble cycle", first, exp_first);
        check(got.size() == n, req, "nibbles on line", got.size(), n);
        for (int i = 0; i < got.size() && i < n; i++) begin
            if (got[i] != base + 4'(i)) begin
                if (mism == 0) begin bad_act = int'(got[i]); bad_exp = int'(base + 4'(i)); end
                mism++;
            end
        end
        check(mism == 0, req, "frame content (first bad nibble)", bad_act, bad_exp);
        if (last >= 0) check(last - first + 1 == n, req, "frame contiguous length", last - first + 1, n);
        if (exp_col >= 0) begin
            // R6: col lasts through the jam and falls the cycle after txen drops
            check(col_cnt == JAM + 1, "R6", "collision length", col_cnt, JAM + 1);
            for (int c = s + 1; c <= g2; c++) if (!crs_hist[c]) crs_gap++;
            // R7 / R9: crs held through the ignored grant until the later one
            check(crs_gap == 0, "R9", "crs low cycles before retry grant", crs_gap, 0);
            check(crs_hist[g2 + 1] == 1'b0, "R7", "crs after retry grant", int'(crs_hist[g2 + 1]), 0);
        end else if (last >= 0) begin
            for (int c = s + 1; c <= last; c++) if (!crs_hist[c]) crs_gap++;
            check(crs_gap == 0, req, "crs low cycles during frame", crs_gap, 0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(line_txen == 1'b0, "R1", "line_txen after reset", int'(line_txen), 0);
        check(mac_crs == 1'b0, "R1", "crs after reset", int'(mac_crs), 0);
        check(mac_col == 1'b0, "R1", "col after reset", int'(mac_col), 0);
    endtask

    // R4: frame begins in the grant cycle -> pass-through
    task automatic t_bypass();
        run_case("R4", 0, 10, 0, -1, -1, 1, 4'h3);
    endtask

    // R4: frame begins inside the open window
    task automatic t_window();
        run_case("R4", 3, 6, 0, -1, -1, 4, 4'h7);
    endtask

    // R10: window expired (open cycles 1..4), frame at 5 is held until grant at 12
    task automatic t_expiry();
        run_case("R10", 5, 5, 0, 12, -1, 13, 4'h1);
    endtask

    // R2 / R3: held frame replayed after an early grant
    task automatic t_buffered();
        run_case("R3", 0, 20, 5, -1, -1, 6, 4'h0);
    endtask

    // R3: short frame ended before the grant
    task automatic t_short();
        run_case("R3", 0, 6, 15, -1, -1, 16, 4'h9);
    endtask

    // R8: DEPTH-th nibble written in the grant cycle (cycle DEPTH-1)
    task automatic t_corner();
        run_case("R8", 0, 20, DEPTH - 1, -1, -1, DEPTH, 4'h5);
    endtask

    // R5 / R9: grant one cycle late collides; that grant is ignored; retry after g2
    task automatic t_collide();
        run_case("R5", 0, 20, DEPTH, 30, DEPTH, 32, 4'hC);
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bypass();
        t_window();
        t_expiry();
        t_buffered();
        t_short();
        t_corner();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule